// File: doc/BRIEF.md
# Entropy Health-Test Statistics Unit

This block watches a narrow raw random-bit stream while the noise source is running. It applies two repetition tests to every accepted word. The first test works lane by lane: each bit is compared with the same bit of the previous word. The second test works on the symbol: the whole word is compared with the previous word. Each test has its own programmable threshold. The block keeps diagnostic values that software can read: the highest lane count and the highest symbol count seen so far, an alert counter for each test, and a total failure counter. It also drives a one-cycle failure pulse and a sticky threshold-alert flag.

The run state follows the `enable_i` control with a lag of one register. That run state drives the RNG enable line back to the source and also the ready side of the sample handshake. A word transfers on a clock edge where `rng_valid_i` and `rng_ready_o` are both high. While the block is running, ready is held high, so the source never sees back-pressure. While it is stopped, ready is low and any word offered is not taken. The statistics stay frozen and readable while the block is stopped. They are wiped when the block starts again, and they are also wiped by reset.

Top module: `ht_stat_unit`

## Requirements
- R1: After reset, every statistic, `fail_o`, `thr_alert_o`, `rng_enable_o` and `rng_ready_o` read 0.
- R2: On each accepted word, each lane's count updates. If the lane bit equals that lane's bit in the previous accepted word, the count increments, saturating at all ones. Otherwise, and always for the first word after a clear, the count becomes 1. `max_bit_o` holds the largest lane count produced since the last clear.
- R3: The symbol count follows the same rule, applied to the whole word. `max_sym_o` is rewritten only when the new symbol count exceeds the stored value.
- R4: The lane test fails on an accepted word when `bit_thresh_i` is non-zero and any lane count reaches it (count >= threshold). `fail_o` is high in the cycle after each failing word and low after any other cycle. Each lane-test failure adds 1 to `bit_alert_cnt_o`.
- R5: The symbol test fails under the same rule, using `sym_thresh_i`. Each symbol-test failure adds 1 to `sym_alert_cnt_o`. A threshold of 0 disables that test.
- R6: The alert counters saturate at all ones (7 with the default width) and never wrap.
- R7: `fail_total_o` adds 1 for each test that fails on a word, so it adds 2 when both fail on the same word. It saturates at all ones (15 with the default width) and never wraps.
- R8: `rng_enable_o` and `rng_ready_o` equal the value `enable_i` had one clock earlier. The enable line therefore drops exactly one cycle after a disable request.
- R9: While `rng_ready_o` is low, offered words are not accepted and change no statistic.
- R10: While the block is stopped, all diagnostic values are held unchanged.
- R11: On the edge where `enable_i` is high and the run state is still low, every statistic and the previous-word history are cleared.
- R12: `thr_alert_o` is set by any failure. It is cleared by reset, by the start edge and by the stop edge (`enable_i` low while running). A clear takes priority over a set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run request |
| rng_valid_i | input | 1 | Sample word valid |
| rng_data_i | input | LANES | Raw sample word |
| rng_ready_o | output | 1 | Sample accepted while high |
| bit_thresh_i | input | CNT_W | Lane-test threshold, 0 disables |
| sym_thresh_i | input | CNT_W | Symbol-test threshold, 0 disables |
| rng_enable_o | output | 1 | Enable line to the noise source |
| fail_o | output | 1 | One-cycle failure pulse |
| thr_alert_o | output | 1 | Sticky threshold alert |
| max_bit_o | output | CNT_W | Highest lane repetition count |
| max_sym_o | output | CNT_W | Highest symbol repetition count |
| bit_alert_cnt_o | output | ALERT_W | Lane-test failure count |
| sym_alert_cnt_o | output | ALERT_W | Symbol-test failure count |
| fail_total_o | output | TOTAL_W | Total failure count |

## Verification
The lane test and the symbol test can both fail on the same accepted word. That cycle must add two to the total counter, must raise the failure pulse only once, and must add one to each alert counter. The bench provokes this by setting both thresholds to 2 and repeating one word many times, so that every repeat fails both tests. The results are compared against hand-computed totals as the total climbs through 14 and then saturates at 15 instead of wrapping. A second coincidence is also exercised: the stop edge clears the alert flag while the frozen counters remain readable.

// File: rtl/ht_stat_pkg.sv
package ht_stat_pkg;

  // Control strobes derived from the run state for one cycle.
  typedef struct packed {
    logic accept;     // a sample word transfers on this edge
    logic clear;      // start edge: wipe statistics and history
    logic alert_clr;  // start or stop edge: drop the sticky alert
  } ht_ctrl_t;

endpackage

// File: rtl/ht_run_ctrl.sv
module ht_run_ctrl
  import ht_stat_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     enable_i,
  input  logic     valid_i,
  output logic     run_o,
  output ht_ctrl_t ctrl_o
);

  logic run_q;
  logic start_edge;
  logic stop_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= enable_i;
  end

  assign start_edge = enable_i & ~run_q;
  assign stop_edge  = ~enable_i & run_q;

  always_comb begin
    ctrl_o.accept    = valid_i & run_q;
    ctrl_o.clear     = start_edge;
    ctrl_o.alert_clr = start_edge | stop_edge;
  end

  assign run_o = run_q;

endmodule

// File: rtl/ht_lane_rep.sv
module ht_lane_rep #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             accept_i,
  input  logic             bit_i,
  input  logic             prev_i,
  input  logic             have_prev_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             hit_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             repeat_bit;

  assign repeat_bit = have_prev_i & (bit_i == prev_i);

  always_comb begin
    if (repeat_bit) cnt_nxt_o = (&cnt_q) ? cnt_q : cnt_q + ONE;
    else            cnt_nxt_o = ONE;
  end

  assign hit_o = accept_i & (|thresh_i) & (cnt_nxt_o >= thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (accept_i) cnt_q <= cnt_nxt_o;
  end

endmodule

// File: rtl/ht_sym_rep.sv
module ht_sym_rep #(
  parameter int LANES = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             accept_i,
  input  logic [LANES-1:0] word_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic [LANES-1:0] prev_o,
  output logic             have_prev_o,
  output logic [CNT_W-1:0] max_o,
  output logic             hit_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [LANES-1:0] prev_q;
  logic             have_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] max_q;

  always_comb begin
    if (have_q && (word_i == prev_q)) cnt_nxt = (&cnt_q) ? cnt_q : cnt_q + ONE;
    else                              cnt_nxt = ONE;
  end

  assign hit_o = accept_i & (|thresh_i) & (cnt_nxt >= thresh_i);

  // History is written after the comparison, on the same accepted edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      have_q <= 1'b0;
      cnt_q  <= '0;
      max_q  <= '0;
    end else if (clear_i) begin
      prev_q <= '0;
      have_q <= 1'b0;
      cnt_q  <= '0;
      max_q  <= '0;
    end else if (accept_i) begin
      prev_q <= word_i;
      have_q <= 1'b1;
      cnt_q  <= cnt_nxt;
      if (cnt_nxt > max_q) max_q <= cnt_nxt;
    end
  end

  assign prev_o      = prev_q;
  assign have_prev_o = have_q;
  assign max_o       = max_q;

endmodule

// File: rtl/ht_sat_cnt.sv
module ht_sat_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic [1:0]   inc_i,
  output logic [W-1:0] q_o
);

  localparam logic [W:0] TOP = {1'b0, {W{1'b1}}};

  logic [W-1:0] q;
  logic [W:0]   sum;

  assign sum = {1'b0, q} + (W+1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (clear_i) q <= '0;
    else if (sum > TOP) q <= {W{1'b1}};
    else              q <= sum[W-1:0];
  end

  assign q_o = q;

endmodule

// File: rtl/ht_stat_unit.sv
module ht_stat_unit
  import ht_stat_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int CNT_W   = 8,
  parameter int ALERT_W = 3,
  parameter int TOTAL_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               rng_valid_i,
  input  logic [LANES-1:0]   rng_data_i,
  output logic               rng_ready_o,
  input  logic [CNT_W-1:0]   bit_thresh_i,
  input  logic [CNT_W-1:0]   sym_thresh_i,
  output logic               rng_enable_o,
  output logic               fail_o,
  output logic               thr_alert_o,
  output logic [CNT_W-1:0]   max_bit_o,
  output logic [CNT_W-1:0]   max_sym_o,
  output logic [ALERT_W-1:0] bit_alert_cnt_o,
  output logic [ALERT_W-1:0] sym_alert_cnt_o,
  output logic [TOTAL_W-1:0] fail_total_o
);

  ht_ctrl_t         ctrl;
  logic             run;
  logic [LANES-1:0] prev_word;
  logic             have_prev;
  logic             sym_hit;
  logic [LANES-1:0] lane_hit;
  logic [CNT_W-1:0] lane_nxt [LANES];
  logic [CNT_W-1:0] lane_peak;
  logic             bit_hit;
  logic [CNT_W-1:0] max_bit_q;
  logic             fail_q;
  logic             alert_q;

  ht_run_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .valid_i  (rng_valid_i),
    .run_o    (run),
    .ctrl_o   (ctrl)
  );

  ht_sym_rep #(.LANES(LANES), .CNT_W(CNT_W)) u_sym (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (ctrl.clear),
    .accept_i    (ctrl.accept),
    .word_i      (rng_data_i),
    .thresh_i    (sym_thresh_i),
    .prev_o      (prev_word),
    .have_prev_o (have_prev),
    .max_o       (max_sym_o),
    .hit_o       (sym_hit)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ht_lane_rep #(.CNT_W(CNT_W)) u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clear_i     (ctrl.clear),
      .accept_i    (ctrl.accept),
      .bit_i       (rng_data_i[g]),
      .prev_i      (prev_word[g]),
      .have_prev_i (have_prev),
      .thresh_i    (bit_thresh_i),
      .cnt_nxt_o   (lane_nxt[g]),
      .hit_o       (lane_hit[g])
    );
  end

  always_comb begin
    lane_peak = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_nxt[i] > lane_peak) lane_peak = lane_nxt[i];
    end
  end

  assign bit_hit = |lane_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_bit_q <= '0;
      fail_q    <= 1'b0;
      alert_q   <= 1'b0;
    end else begin
      fail_q <= bit_hit | sym_hit;
      if (ctrl.clear) max_bit_q <= '0;
      else if (ctrl.accept && (lane_peak > max_bit_q)) max_bit_q <= lane_peak;
      if (ctrl.alert_clr)        alert_q <= 1'b0;
      else if (bit_hit | sym_hit) alert_q <= 1'b1;
    end
  end

  ht_sat_cnt #(.W(ALERT_W)) u_bit_alert (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (ctrl.clear),
    .inc_i   ({1'b0, bit_hit}),
    .q_o     (bit_alert_cnt_o)
  );

  ht_sat_cnt #(.W(ALERT_W)) u_sym_alert (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (ctrl.clear),
    .inc_i   ({1'b0, sym_hit}),
    .q_o     (sym_alert_cnt_o)
  );

  ht_sat_cnt #(.W(TOTAL_W)) u_total (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (ctrl.clear),
    .inc_i   ({bit_hit & sym_hit, bit_hit ^ sym_hit}),
    .q_o     (fail_total_o)
  );

  assign rng_enable_o = run;
  assign rng_ready_o  = run;
  assign fail_o       = fail_q;
  assign thr_alert_o  = alert_q;
  assign max_bit_o    = max_bit_q;

endmodule

// File: rtl/ht_stat_unit_chk.sv
module ht_stat_unit_chk #(
  parameter int LANES   = 4,
  parameter int CNT_W   = 8,
  parameter int ALERT_W = 3,
  parameter int TOTAL_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               enable_i,
  input logic               rng_valid_i,
  input logic               rng_ready_o,
  input logic               rng_enable_o,
  input logic               fail_o,
  input logic               thr_alert_o,
  input logic [CNT_W-1:0]   max_bit_o,
  input logic [CNT_W-1:0]   max_sym_o,
  input logic [ALERT_W-1:0] bit_alert_cnt_o,
  input logic [ALERT_W-1:0] sym_alert_cnt_o,
  input logic [TOTAL_W-1:0] fail_total_o
);

  AST_EN_RISE_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |=> rng_enable_o);  // R8
  AST_EN_FALL_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !rng_enable_o);  // R8
  AST_FAIL_NEEDS_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> $past(rng_valid_i && rng_ready_o));  // R4
  AST_MAX_SYM_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rng_enable_o |=> (max_sym_o >= $past(max_sym_o)));  // R3
  AST_BIT_ALERT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rng_enable_o && (&bit_alert_cnt_o)) |=> (&bit_alert_cnt_o));  // R6
  AST_TOTAL_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rng_enable_o |=> (fail_total_o >= $past(fail_total_o)));  // R7
  AST_FROZEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !rng_enable_o) |=> ($stable(max_bit_o) && $stable(max_sym_o)
      && $stable(bit_alert_cnt_o) && $stable(sym_alert_cnt_o) && $stable(fail_total_o)));  // R10
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !rng_enable_o) |=> (fail_total_o == '0 && max_sym_o == '0 && !thr_alert_o));  // R11
  AST_STOP_DROPS_ALERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && rng_enable_o) |=> !thr_alert_o);  // R12

endmodule

bind ht_stat_unit ht_stat_unit_chk #(
  .LANES(LANES), .CNT_W(CNT_W), .ALERT_W(ALERT_W), .TOTAL_W(TOTAL_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .enable_i        (enable_i),
  .rng_valid_i     (rng_valid_i),
  .rng_ready_o     (rng_ready_o),
  .rng_enable_o    (rng_enable_o),
  .fail_o          (fail_o),
  .thr_alert_o     (thr_alert_o),
  .max_bit_o       (max_bit_o),
  .max_sym_o       (max_sym_o),
  .bit_alert_cnt_o (bit_alert_cnt_o),
  .sym_alert_cnt_o (sym_alert_cnt_o),
  .fail_total_o    (fail_total_o)
);

// File: tb/ht_stat_unit_tb_top.sv
module ht_stat_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LANES   = 4;
  localparam int CNT_W   = 8;
  localparam int ALERT_W = 3;
  localparam int TOTAL_W = 4;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               enable_i = 1'b0;
  logic               rng_valid_i = 1'b0;
  logic [LANES-1:0]   rng_data_i = '0;
  logic               rng_ready_o;
  logic [CNT_W-1:0]   bit_thresh_i = '0;
  logic [CNT_W-1:0]   sym_thresh_i = '0;
  logic               rng_enable_o;
  logic               fail_o;
  logic               thr_alert_o;
  logic [CNT_W-1:0]   max_bit_o;
  logic [CNT_W-1:0]   max_sym_o;
  logic [ALERT_W-1:0] bit_alert_cnt_o;
  logic [ALERT_W-1:0] sym_alert_cnt_o;
  logic [TOTAL_W-1:0] fail_total_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ht_stat_unit #(.LANES(LANES), .CNT_W(CNT_W), .ALERT_W(ALERT_W), .TOTAL_W(TOTAL_W)) dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .enable_i (enable_i),
    .rng_valid_i (rng_valid_i), .rng_data_i (rng_data_i), .rng_ready_o (rng_ready_o),
    .bit_thresh_i (bit_thresh_i), .sym_thresh_i (sym_thresh_i),
    .rng_enable_o (rng_enable_o), .fail_o (fail_o), .thr_alert_o (thr_alert_o),
    .max_bit_o (max_bit_o), .max_sym_o (max_sym_o),
    .bit_alert_cnt_o (bit_alert_cnt_o), .sym_alert_cnt_o (sym_alert_cnt_o),
    .fail_total_o (fail_total_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Offer one word for one edge; results are read at the following falling edge.
  task automatic push(input logic [LANES-1:0] w);
    rng_data_i  = w;
    rng_valid_i = 1'b1;
    @(negedge clk);
    rng_valid_i = 1'b0;
  endtask

  task automatic start_run();
    enable_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic stop_run();
    enable_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "enable", int'(rng_enable_o), 0);
    chk("R1", "ready", int'(rng_ready_o), 0);
    chk("R1", "fail", int'(fail_o), 0);
    chk("R1", "alert", int'(thr_alert_o), 0);
    chk("R1", "max_bit", int'(max_bit_o), 0);
    chk("R1", "total", int'(fail_total_o), 0);
  endtask

  task automatic t_lane_counts();
    bit_thresh_i = '0; sym_thresh_i = '0;
    start_run();
    chk("R8", "enable after request", int'(rng_enable_o), 1);
    chk("R8", "ready after request", int'(rng_ready_o), 1);
    push(4'b0000);
    chk("R2", "first word lane max", int'(max_bit_o), 1);
    chk("R3", "first word sym max", int'(max_sym_o), 1);
    push(4'b0000);
    chk("R2", "repeat lane max", int'(max_bit_o), 2);
    chk("R3", "repeat sym max", int'(max_sym_o), 2);
    push(4'b0001);
    chk("R2", "lane max after one flip", int'(max_bit_o), 3);
    chk("R3", "sym max kept when lower", int'(max_sym_o), 2);
    push(4'b0011);
    chk("R2", "lane max grows", int'(max_bit_o), 4);
    chk("R3", "sym max kept", int'(max_sym_o), 2);
    chk("R5", "zero thresholds never fail", int'(fail_total_o), 0);
    stop_run();
  endtask

  task automatic t_bit_fail();
    bit_thresh_i = 8'd3; sym_thresh_i = '0;
    start_run();
    chk("R11", "max_bit cleared", int'(max_bit_o), 0);
    chk("R11", "max_sym cleared", int'(max_sym_o), 0);
    push(4'b0000);
    push(4'b0000);
    chk("R4", "no fail below threshold", int'(fail_o), 0);
    push(4'b0001);
    chk("R4", "fail pulse at threshold", int'(fail_o), 1);
    chk("R4", "bit alert 1", int'(bit_alert_cnt_o), 1);
    chk("R12", "alert set", int'(thr_alert_o), 1);
    push(4'b0010);
    push(4'b0101);
    chk("R4", "bit alert 3", int'(bit_alert_cnt_o), 3);
    chk("R2", "lane max 5", int'(max_bit_o), 5);
    push(4'b1111);
    chk("R4", "pulse drops on passing word", int'(fail_o), 0);
    chk("R12", "alert sticky", int'(thr_alert_o), 1);
    for (int i = 0; i < 4; i++) push(4'b1111);
    chk("R6", "bit alert reaches 7", int'(bit_alert_cnt_o), 7);
    push(4'b1111);
    push(4'b1111);
    chk("R6", "bit alert saturated", int'(bit_alert_cnt_o), 7);
    chk("R7", "total 9", int'(fail_total_o), 9);
    chk("R5", "sym alert untouched", int'(sym_alert_cnt_o), 0);
    chk("R3", "sym max 7", int'(max_sym_o), 7);
    stop_run();
  endtask

  task automatic t_sym_fail();
    bit_thresh_i = '0; sym_thresh_i = 8'd3;
    start_run();
    push(4'b1001);
    push(4'b1001);
    chk("R5", "no sym fail below threshold", int'(fail_o), 0);
    push(4'b1001);
    chk("R5", "sym fail pulse", int'(fail_o), 1);
    chk("R5", "sym alert 1", int'(sym_alert_cnt_o), 1);
    chk("R5", "bit alert 0", int'(bit_alert_cnt_o), 0);
    chk("R7", "total 1", int'(fail_total_o), 1);
    stop_run();
  endtask

  task automatic t_dual_fail();
    bit_thresh_i = 8'd2; sym_thresh_i = 8'd2;
    start_run();
    push(4'b0110);
    push(4'b0110);
    chk("R7", "both fail adds two", int'(fail_total_o), 2);
    chk("R4", "bit alert 1", int'(bit_alert_cnt_o), 1);
    chk("R5", "sym alert 1", int'(sym_alert_cnt_o), 1);
    for (int i = 0; i < 6; i++) push(4'b0110);
    chk("R7", "total 14", int'(fail_total_o), 14);
    push(4'b0110);
    chk("R7", "total saturates at 15", int'(fail_total_o), 15);
    push(4'b0110);
    chk("R7", "total stays 15", int'(fail_total_o), 15);
    chk("R6", "sym alert saturated", int'(sym_alert_cnt_o), 7);
    chk("R3", "sym max 10", int'(max_sym_o), 10);
  endtask

  task automatic t_stop_hold();
    enable_i = 1'b0;
    #1;
    chk("R8", "enable still high same cycle", int'(rng_enable_o), 1);
    @(negedge clk);
    chk("R8", "enable low one cycle later", int'(rng_enable_o), 0);
    chk("R12", "alert cleared on stop", int'(thr_alert_o), 0);
    chk("R10", "total held", int'(fail_total_o), 15);
    rng_data_i = 4'b0110; rng_valid_i = 1'b1;
    for (int i = 0; i < 5; i++) @(negedge clk);
    chk("R9", "ready low while stopped", int'(rng_ready_o), 0);
    rng_valid_i = 1'b0;
    chk("R9", "sym max unchanged", int'(max_sym_o), 10);
    chk("R9", "fail stays low", int'(fail_o), 0);
    chk("R10", "bit alert held", int'(bit_alert_cnt_o), 7);
  endtask

  task automatic t_restart_clear();
    start_run();
    chk("R11", "total cleared", int'(fail_total_o), 0);
    chk("R11", "sym alert cleared", int'(sym_alert_cnt_o), 0);
    chk("R11", "max_sym cleared", int'(max_sym_o), 0);
    bit_thresh_i = '0; sym_thresh_i = '0;
    push(4'b0110);
    chk("R11", "history wiped, count restarts", int'(max_sym_o), 1);
    stop_run();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    fork
      begin
        t_reset();
        t_lane_counts();
        t_bit_fail();
        t_sym_fail();
        t_dual_fail();
        t_stop_hold();
        t_restart_clear();
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule